// File: doc/BRIEF.md
# Calibrated Seconds Tick Generator

This block turns a free-running oscillator clock into a pulse that marks each elapsed second. The length of a second is set by a calibration word: an integer tick limit, plus an optional fractional trim that lengthens some seconds by a single oscillator cycle. The lengthened seconds are chosen inside a repeating frame of sixteen seconds. Their number sets the average second length to a resolution finer than one oscillator period.

Software writes the calibration word through a write strobe and a 32-bit data bus. The stored word is always visible on a separate read-back bus. A written value is held aside and is only put to use when the running second ends. Retiming to a bus clock, the oscillator itself, and the conversion of a frequency offset into a calibration word belong to the surrounding logic.

Top module: `rtc_sec_tick`

## Requirements
- R1: After reset the stored calibration reads back as 0x00007FFF with fractional trim off. The pulse output is low, and the first pulse appears exactly 32768 oscillator cycles after reset is released.
- R2: With fractional trim off, consecutive pulses are spaced by the value in calibration bits [15:0] plus one cycle.
- R3: The read-back bus returns bits [20:0] of the last written word, and bits [31:21] always read as zero.
- R4: A written calibration is used starting with the second after the one in progress, so the running second keeps its old length. A write landing on the cycle that ends a second is used one second later.
- R5: Each pulse is high for exactly one oscillator cycle, provided the tick limit is at least 1.
- R6: With bit 20 set and bits [19:16] equal to N, exactly N seconds of every aligned 16-second frame are one cycle longer than the integer length.
- R7: Seconds are numbered 0 to 15 within a frame, and frame 0 begins with the first second after reset. Second s is lengthened when floor((s+1)·N/16) exceeds floor(s·N/16), which spreads the long seconds evenly.
- R8: When bit 20 is clear, bits [19:16] have no effect on second length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calWrEn | input | 1 | Calibration write strobe, one cycle |
| calWrData | input | 32 | Calibration word to store |
| calRdData | output | 32 | Stored calibration word |
| secPulse | output | 1 | One-cycle pulse at the end of each second |

## Verification
The bench keeps the default reset calibration of 0x7FFF, so the full 32768-cycle first second is measured end to end. A write placed inside that second also confirms that the running second is not cut short. After that it programs tick limits of 20 or fewer cycles. With limits that small, many whole 16-second frames fit in the run, which lets it count and place the lengthened seconds for trim values 0, 1, 5 and 15. A stretch of writes at random times, some of them on boundary cycles, is then compared cycle by cycle with a behavioural model.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  localparam int TICK_W      = 16;
  localparam int FRAC_W      = 4;
  localparam int FRAC_LSB    = 16;
  localparam int FRAC_EN_BIT = FRAC_LSB + FRAC_W;
  localparam int CAL_W       = FRAC_EN_BIT + 1;
  localparam int CNT_W       = TICK_W + 1;
  localparam logic [31:0] CAL_MASK = 32'((64'd1 << CAL_W) - 64'd1);

  typedef struct packed {
    logic [TICK_W-1:0] maxTick;
    logic              stretch;
  } tickCtl_t;
endpackage

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_tick_pkg::*;
#(
  parameter logic [31:0] CAL_RESET = 32'h0000_7FFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        calWrEn,
  input  logic [31:0] calWrData,
  input  logic        secEnd,
  output logic [31:0] calRdData,
  output tickCtl_t    tickCtl
);
  localparam logic [31:0] RESET_WORD = CAL_RESET & CAL_MASK;

  logic [31:0]       shadowCal;
  logic [TICK_W-1:0] activeMax;
  logic [FRAC_W-1:0] activeFrac;
  logic              activeFracOn;
  logic [FRAC_W-1:0] secIdx;

  // Pending word: written any time and read back directly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCal <= RESET_WORD;
    end else if (calWrEn) begin
      shadowCal <= calWrData & CAL_MASK;
    end
  end

  // Active settings and frame position move only at a second boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMax    <= RESET_WORD[TICK_W-1:0];
      activeFrac   <= RESET_WORD[FRAC_LSB +: FRAC_W];
      activeFracOn <= RESET_WORD[FRAC_EN_BIT];
      secIdx       <= '0;
    end else if (secEnd) begin
      activeMax    <= shadowCal[TICK_W-1:0];
      activeFrac   <= shadowCal[FRAC_LSB +: FRAC_W];
      activeFracOn <= shadowCal[FRAC_EN_BIT];
      secIdx       <= secIdx + 1'b1;
    end
  end

  // Second s is stretched when (s*N mod 16) + N carries out of FRAC_W bits
  logic [FRAC_W-1:0] fracN;
  logic [FRAC_W-1:0] prodLow;
  logic [FRAC_W:0]   carrySum;

  always_comb begin
    fracN    = activeFracOn ? activeFrac : '0;
    prodLow  = secIdx * fracN;
    carrySum = {1'b0, prodLow} + {1'b0, fracN};
    tickCtl.maxTick = activeMax;
    tickCtl.stretch = carrySum[FRAC_W];
  end

  assign calRdData = shadowCal;
endmodule

// File: rtl/rtc_tick_dp.sv
module rtc_tick_dp
  import rtc_tick_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  tickCtl_t tickCtl,
  output logic     secEnd,
  output logic     secPulse
);
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] tickLimit;

  always_comb begin
    tickLimit = {1'b0, tickCtl.maxTick} + CNT_W'(tickCtl.stretch);
    secEnd    = (tickCnt == tickLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      secPulse <= 1'b0;
    end else begin
      tickCnt  <= secEnd ? '0 : tickCnt + 1'b1;
      secPulse <= secEnd;
    end
  end
endmodule

// File: rtl/rtc_sec_tick.sv
module rtc_sec_tick
  import rtc_tick_pkg::*;
#(
  parameter logic [31:0] CAL_RESET = 32'h0000_7FFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        calWrEn,
  input  logic [31:0] calWrData,
  output logic [31:0] calRdData,
  output logic        secPulse
);
  tickCtl_t tickCtl;
  logic     secEnd;

  rtc_cal_ctrl #(.CAL_RESET(CAL_RESET)) uCtrl (
    .clk(clk), .rstN(rstN), .calWrEn(calWrEn), .calWrData(calWrData),
    .secEnd(secEnd), .calRdData(calRdData), .tickCtl(tickCtl)
  );

  rtc_tick_dp uDp (
    .clk(clk), .rstN(rstN), .tickCtl(tickCtl),
    .secEnd(secEnd), .secPulse(secPulse)
  );
endmodule

// File: rtl/rtc_sec_tick_chk.sv
module rtc_sec_tick_chk
  import rtc_tick_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        secPulse,
  input logic        secEnd,
  input logic [31:0] calRdData,
  input tickCtl_t    tickCtl
);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    calRdData[31:CAL_W] == '0);

  a_r4_hold_in_second: assert property (@(posedge clk) disable iff (!rstN)
    !secEnd |=> $stable(tickCtl));

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (secPulse && tickCtl.maxTick != '0) |=> !secPulse);

  a_r2_end_gives_pulse: assert property (@(posedge clk) disable iff (!rstN)
    secEnd |=> secPulse);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !secEnd |=> !secPulse);
endmodule

bind rtc_sec_tick rtc_sec_tick_chk uChk (
  .clk(clk), .rstN(rstN), .secPulse(secPulse), .secEnd(secEnd),
  .calRdData(calRdData), .tickCtl(tickCtl)
);

// File: tb/test_rtc_sec_tick.sv
module test_rtc_sec_tick;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        calWrEn = 1'b0;
  logic [31:0] calWrData = '0;
  logic [31:0] calRdData;
  logic        secPulse;

  int checks = 0;
  int fails = 0;
  longint cycleCnt = 0;
  longint relCycle = 0;
  longint pulseT[$];
  bit modelOn = 0;
  bit prevPulse = 0;

  always #2 clk = ~clk;

  rtc_sec_tick i_rtc_sec_tick (
    .clk(clk), .rstN(rstN), .calWrEn(calWrEn), .calWrData(calWrData),
    .calRdData(calRdData), .secPulse(secPulse)
  );

  function automatic int expLen(logic [31:0] cal, int s);
    int mt = int'(cal[15:0]);
    int n  = cal[20] ? int'(cal[19:16]) : 0;
    return mt + 1 + ((s + 1) * n) / 16 - (s * n) / 16;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: elapsed cycles versus the length of the current second
  logic [31:0] mShadow, mActive;
  int mSec, mElapsed, mLen;
  bit mPulse;

  always @(posedge clk) begin
    cycleCnt++;
    if (!rstN) begin
      mShadow = 32'h7FFF; mActive = 32'h7FFF; mSec = 0;
      mElapsed = 0; mLen = expLen(mActive, 0); mPulse = 0; modelOn = 1;
    end else begin
      mElapsed++;
      mPulse = (mElapsed == mLen);
      if (mPulse) begin
        mElapsed = 0;
        mActive = mShadow;
        mSec = (mSec + 1) % 16;
        mLen = expLen(mActive, mSec);
      end
      if (calWrEn) mShadow = calWrData & 32'h001F_FFFF;
    end
  end

  always @(negedge clk) begin
    if (modelOn && rstN) begin
      check(secPulse == mPulse, "R4 pulse timing", secPulse, mPulse);
      check(calRdData == mShadow, "R3 read-back", calRdData, mShadow);
      if (secPulse) begin
        check(!prevPulse, "R5 one-cycle pulse", prevPulse, 0);
        pulseT.push_back(cycleCnt);
      end
      prevPulse = secPulse;
    end
  end

  function automatic longint interval(int p);
    return (p == 0) ? pulseT[0] - relCycle : pulseT[p] - pulseT[p-1];
  endfunction

  task automatic waitPulses(int n);
    while (pulseT.size() < n) @(negedge clk);
  endtask

  task automatic writeCal(logic [31:0] v);
    calWrEn = 1'b1; calWrData = v;
    @(negedge clk);
    calWrEn = 1'b0;
  endtask

  // Write just after a boundary, then check the seconds that follow the running one
  task automatic runCal(logic [31:0] cal, int nsec, string req);
    int p0;
    int frameStart;
    int longCnt;
    int n;
    waitPulses(pulseT.size() + 1);
    p0 = pulseT.size();
    writeCal(cal);
    check(calRdData == (cal & 32'h001F_FFFF), "R3 masked read-back",
          calRdData, cal & 32'h001F_FFFF);
    waitPulses(p0 + 1 + nsec);
    for (int p = p0 + 1; p <= p0 + nsec; p++)
      check(interval(p) == expLen(cal, p % 16), req, interval(p), expLen(cal, p % 16));
    if (cal[20] && nsec >= 31) begin
      frameStart = ((p0 + 1 + 15) / 16) * 16;
      longCnt = 0;
      n = int'(cal[19:16]);
      for (int p = frameStart; p < frameStart + 16; p++)
        if (interval(p) == int'(cal[15:0]) + 2) longCnt++;
      check(longCnt == n, "R6 long seconds per frame", longCnt, n);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    relCycle = cycleCnt;
    @(negedge clk);
    check(calRdData == 32'h7FFF, "R1 reset calibration", calRdData, 32'h7FFF);
    check(secPulse == 1'b0, "R1 reset pulse low", secPulse, 0);
    writeCal(32'd5);
    waitPulses(1);
    check(interval(0) == 32768, "R1 R4 first second length kept", interval(0), 32768);
    waitPulses(4);
    for (int p = 1; p < 4; p++)
      check(interval(p) == 6, "R2 integer period", interval(p), 6);

    runCal(32'h000F_0009, 4, "R8 trim bits ignored when disabled");
    runCal(32'hFFEF_0009, 4, "R8 R3 upper bits dropped");
    runCal(32'h0015_0007, 32, "R7 placement N=5");
    runCal(32'h001F_0003, 32, "R7 placement N=15");
    runCal(32'h0011_0004, 32, "R7 placement N=1");
    runCal(32'h0010_0005, 32, "R6 enabled with N=0");

    // Writes at arbitrary times, boundary cycles included, checked by the model
    for (int i = 0; i < 300; i++) begin
      repeat ($urandom_range(0, 30)) @(negedge clk);
      writeCal({$urandom_range(0, 2047), 5'($urandom), 16'($urandom_range(2, 20))});
    end
    repeat (200) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule